// File: doc/BRIEF.md
# Priority Bus Access Timer

This block decides when a local transmitter may begin a message on a shared serial line whose idle level is high. It counts bit-time ticks during which the line stays high. Once that count reaches a wait length set by the message priority, it grants the bus to a pending request. Any low level seen on the line clears the count, so the wait starts over. A more urgent message (a lower level number) needs a shorter wait, so it wins the line when several nodes are waiting.

While the grant is held, the requester sends its bytes back to back. It signals the end of the message with a one-cycle pulse. The block then keeps itself busy for a fixed minimum gap of bit times and clears its idle count. Every following message therefore waits out its full priority window, counted from the end of the previous one.

Top module: `bus_access_timer`

## Requirements
- R1: After reset, `grant_o` and `busy_o` are both 0, and the idle count starts from zero.
- R2: For a level L from 1 to 8 on `prio_i`, the required idle wait is 10 + 2*L bit ticks. Level 1 needs 12 ticks and level 5 needs 20.
- R3: A `prio_i` value of 0 or above 8 is treated as level 8, which needs 26 ticks.
- R4: A low level on `bus_line_i` passes through a two-flop synchroniser. When it arrives it clears the idle count, and the full wait begins again.
- R5: The idle count advances only on cycles where `bit_tick_i` is 1 and the synchronised line is high. `grant_o` rises one clock after the count reaches the required wait while `req_i` is 1.
- R6: Once `grant_o` is 1, it stays 1 until `eom_i` is seen, whatever `req_i`, `bus_line_i` or `bit_tick_i` do.
- R7: `grant_o` falls one clock after `eom_i`. `busy_o` then stays 1 for exactly 10 further bit ticks and falls at the 10th.
- R8: The end of a message clears the idle count. The next grant therefore needs the full priority wait counted from `eom_i`, even with `req_i` held high throughout.
- R9: With `req_i` at 0, `grant_o` stays 0 however long the line is idle.
- R10: The idle count saturates at 26 and keeps counting while no request is pending. A request after a long enough idle period is granted one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| bus_line_i | input | 1 | Asynchronous bus line level, high when idle |
| prio_i | input | 4 | Message priority level, 1 is the most urgent |
| req_i | input | 1 | Transmit request |
| eom_i | input | 1 | One-cycle pulse after the final byte has been sent |
| grant_o | output | 1 | Bus granted to the local transmitter |
| busy_o | output | 1 | Grant held or post-message gap running |

## Verification
The hardest situation to reach is the one just after a message ends. In it, the post-message gap and the priority wait overlap, and a request is still pending. The bench holds `req_i` high through `eom_i` and counts ticks across the gap. It checks that `busy_o` falls exactly at the 10th tick. It also checks that the grant returns only at the full priority length, not at the end of the gap. A second hard case is a line that drops low partway through a wait. The bench holds the line low long enough to cross the synchroniser and then checks that the count starts again from zero.

// File: rtl/bat_pkg.sv
package bat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_GAP   = 2'd2
  } bat_state_e;
endpackage

// File: rtl/bat_sync.sv
module bat_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/bat_idle_cnt.sv
module bat_idle_cnt #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned SAT   = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] SatVal = CNT_W'(SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clr_i || !line_i)           cnt_o <= '0;
    else if (tick_i && cnt_o != SatVal)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/bat_ctrl.sv
module bat_ctrl
  import bat_pkg::*;
#(
  parameter int unsigned GAP_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req_i,
  input  logic eom_i,
  input  logic ready_i,
  output logic grant_o,
  output logic busy_o,
  output logic gap_start_o
);
  localparam int unsigned GapW = (GAP_BITS > 1) ? $clog2(GAP_BITS) : 1;
  localparam logic [GapW-1:0] GapLast = GapW'(GAP_BITS - 1);

  bat_state_e      state_q;
  logic [GapW-1:0] gap_q;

  assign gap_start_o = (state_q == ST_GRANT) && eom_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (req_i && ready_i) state_q <= ST_GRANT;
        ST_GRANT: if (eom_i) begin
                    state_q <= ST_GAP;
                    gap_q   <= '0;
                  end
        ST_GAP:   if (tick_i) begin
                    if (gap_q == GapLast) state_q <= ST_IDLE;
                    else                  gap_q   <= gap_q + 1'b1;
                  end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign grant_o = (state_q == ST_GRANT);
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/bus_access_timer.sv
module bus_access_timer #(
  parameter int unsigned PRIO_W    = 4,
  parameter int unsigned MAX_LEVEL = 8,
  parameter int unsigned BASE_BITS = 10,
  parameter int unsigned STEP_BITS = 2,
  parameter int unsigned GAP_BITS  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              bus_line_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              req_i,
  input  logic              eom_i,
  output logic              grant_o,
  output logic              busy_o
);
  localparam int unsigned NEED_MAX = BASE_BITS + STEP_BITS * MAX_LEVEL;
  localparam int unsigned CNT_W    = $clog2(NEED_MAX + 1);

  logic             bus_s;
  logic             gap_start;
  logic [CNT_W-1:0] idle_cnt;
  logic [CNT_W-1:0] need;
  logic             ready;

  bat_sync #(.RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_line_i),
    .q_o   (bus_s)
  );

  bat_idle_cnt #(.CNT_W(CNT_W), .SAT(NEED_MAX)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(bit_tick_i),
    .line_i(bus_s),
    .clr_i (gap_start),
    .cnt_o (idle_cnt)
  );

  // level clamp: 0 and above-range map to the least urgent level
  always_comb begin
    int unsigned lvl;
    lvl = int'(prio_i);
    if (lvl == 0 || lvl > MAX_LEVEL) lvl = MAX_LEVEL;
    need = CNT_W'(BASE_BITS + STEP_BITS * lvl);
  end

  assign ready = (idle_cnt >= need);

  bat_ctrl #(.GAP_BITS(GAP_BITS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (bit_tick_i),
    .req_i      (req_i),
    .eom_i      (eom_i),
    .ready_i    (ready),
    .grant_o    (grant_o),
    .busy_o     (busy_o),
    .gap_start_o(gap_start)
  );
endmodule

// File: rtl/bat_checker.sv
module bat_checker #(
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned NEED_MAX = 26
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_s_i,
  input logic [CNT_W-1:0] idle_cnt_i,
  input logic [CNT_W-1:0] need_i,
  input logic             req_i,
  input logic             eom_i,
  input logic             grant_i,
  input logic             busy_i
);
  a_r4_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_s_i |=> idle_cnt_i == '0);

  a_r5_grant_after_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_i) |-> $past(idle_cnt_i >= need_i && req_i));

  a_r6_grant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i && !eom_i |=> grant_i);

  a_r7_gap_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i && eom_i |=> !grant_i && busy_i);

  a_r8_count_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i && eom_i |=> idle_cnt_i == '0);

  a_r10_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cnt_i <= CNT_W'(NEED_MAX));

  a_r7_grant_implies_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> busy_i);
endmodule

bind bus_access_timer bat_checker #(.CNT_W(CNT_W), .NEED_MAX(NEED_MAX)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_s_i   (bus_s),
  .idle_cnt_i(idle_cnt),
  .need_i    (need),
  .req_i     (req_i),
  .eom_i     (eom_i),
  .grant_i   (grant_o),
  .busy_i    (busy_o)
);

// File: tb/bus_access_timer_tb.sv
module bus_access_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic       bus_line_i = 1'b1;
  logic [3:0] prio_i = 4'd1;
  logic       req_i = 1'b0;
  logic       eom_i = 1'b0;
  logic       grant_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  bus_access_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_tick_i(bit_tick_i),
    .bus_line_i(bus_line_i), .prio_i(prio_i), .req_i(req_i),
    .eom_i(eom_i), .grant_o(grant_o), .busy_o(busy_o)
  );

  typedef struct packed {
    logic [3:0] prio;
    logic [4:0] need;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{4'd1,  5'd12},
    '{4'd5,  5'd20},
    '{4'd8,  5'd26},
    '{4'd3,  5'd16},
    '{4'd2,  5'd14},
    '{4'd0,  5'd26},
    '{4'd12, 5'd26}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i) bit_tick_i = 1'b1;
    @(negedge clk_i) bit_tick_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = 1'b0; eom_i = 1'b0; bit_tick_i = 1'b0; bus_line_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    check(grant_o == 1'b0, "R1 grant", grant_o, 0);
    check(busy_o == 1'b0,  "R1 busy",  busy_o, 0);

    // R2 R3 R7 R8: table walk
    for (int i = 0; i < 7; i++) begin
      int need;
      need = int'(VEC[i].need);
      do_reset();
      prio_i = VEC[i].prio;
      req_i  = 1'b1;
      repeat (need - 1) tick();
      @(negedge clk_i);
      check(grant_o == 1'b0, "R2/R3 early", grant_o, 0);
      tick();
      @(negedge clk_i);
      check(grant_o == 1'b1, "R2/R3 on time", grant_o, 1);
      eom_i = 1'b1;
      @(negedge clk_i) eom_i = 1'b0;
      check(grant_o == 1'b0 && busy_o == 1'b1, "R7 gap start", {grant_o, busy_o}, 1);
      repeat (9) tick();
      check(busy_o == 1'b1, "R7 gap 9", busy_o, 1);
      tick();
      check(busy_o == 1'b0, "R7 gap 10", busy_o, 0);
      repeat (need - 11) tick();
      @(negedge clk_i);
      check(grant_o == 1'b0, "R8 early", grant_o, 0);
      tick();
      @(negedge clk_i);
      check(grant_o == 1'b1, "R8 on time", grant_o, 1);
    end

    // R5: no ticks means no progress; R4: line low restarts wait
    do_reset();
    prio_i = 4'd1; req_i = 1'b1;
    repeat (50) @(negedge clk_i);
    check(grant_o == 1'b0, "R5 no tick", grant_o, 0);
    repeat (8) tick();
    bus_line_i = 1'b0;
    repeat (3) @(negedge clk_i);
    bus_line_i = 1'b1;
    repeat (3) @(negedge clk_i);
    repeat (11) tick();
    @(negedge clk_i);
    check(grant_o == 1'b0, "R4 restart early", grant_o, 0);
    tick();
    @(negedge clk_i);
    check(grant_o == 1'b1, "R4 restart on time", grant_o, 1);

    // R6: grant held through req drop, line activity and ticks
    req_i = 1'b0;
    bus_line_i = 1'b0;
    repeat (5) tick();
    bus_line_i = 1'b1;
    repeat (3) tick();
    check(grant_o == 1'b1, "R6 held", grant_o, 1);
    eom_i = 1'b1;
    @(negedge clk_i) eom_i = 1'b0;
    check(grant_o == 1'b0, "R6 released", grant_o, 0);

    // R9 no request; R10 saturated count grants next cycle
    do_reset();
    prio_i = 4'd8;
    repeat (30) tick();
    check(grant_o == 1'b0 && busy_o == 1'b0, "R9 no req", {grant_o, busy_o}, 0);
    req_i = 1'b1;
    @(negedge clk_i);
    check(grant_o == 1'b1, "R10 saturated grant", grant_o, 1);

    done = 1'b1;
    finish_run();
  end
endmodule